// File: doc/BRIEF.md
# SDRAM Device Command Decoder with Bank Tracking

This block is the command front end on the device side of a four-bank SDRAM. On every rising clock edge it samples chip select, the three row/column/write strobes, the two bank-select bits and the 12-bit multiplexed address. It turns that sample into one of seven commands: no-operation, activate, read, write, precharge, auto-refresh or mode-register set. The decoded command comes out one edge later, together with the target bank, the row, the column, the auto-precharge request and the precharge-all flag.

A small tracker keeps an open flag and an open-row register for each bank. It raises a protocol error when a read or write targets a closed bank, or when an activate targets a bank that is already open. Address bit 10 has two jobs. On read and write it requests auto-precharge. On precharge it widens the close to every bank. A registered clock-enable gate stops decoding one edge after clock enable is sampled low, and it shows the resulting power-down state.

Top module: `sdram_cmd_frontend`

## Requirements
- R1: A command is decoded from {ras_ni,cas_ni,we_ni} when cs_ni is low. The mappings are 011 to activate (cmd_o=1), 101 to read (2), 100 to write (3), 010 to precharge (4), 001 to refresh (5) and 000 to mode set (6). Every other pattern gives no-operation (0). cmd_o shows the command sampled at the previous rising edge.
- R2: If cs_ni is high at an edge, the output for that edge is a no-operation with all fields zero, and the bank state does not change.
- R3: If cke_i is low at edge N, power_down_o is high after edge N. The command at edge N+1 is ignored (no-operation, bank state unchanged). Decoding resumes at the first edge after an edge that sampled cke_i high.
- R4: An activate sets bank_o to ba_i and row_o to addr_i. If the bank was closed, it opens and stores that row.
- R5: A read or write sets bank_o to ba_i, col_o to addr_i[7:0], row_o to the open row of that bank (zero if the bank is closed) and auto_pre_o to addr_i[10].
- R6: A read or write with addr_i[10] high, issued to an open bank, closes that bank.
- R7: A precharge with addr_i[10] high sets all_banks_o and closes all four banks, whatever ba_i holds.
- R8: A precharge with addr_i[10] low closes only bank ba_i and leaves all_banks_o low.
- R9: proto_err_o goes high for a read or write to a closed bank, and for an activate to an open bank. An activate that errs leaves the stored row unchanged.
- R10: After reset, all banks are closed, cmd_o is no-operation, proto_err_o is low and power_down_o is low.
- R11: Fields that a command does not use read zero: col_o and auto_pre_o outside read and write, all_banks_o outside precharge, and row_o outside activate, read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable, high lets decoding run |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Multiplexed row/column address |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 2 | Target bank |
| row_o | output | 12 | Row for activate, open row for read/write |
| col_o | output | 8 | Column for read/write |
| auto_pre_o | output | 1 | Auto-precharge requested |
| all_banks_o | output | 1 | Precharge of all banks |
| proto_err_o | output | 1 | Command illegal for current bank state |
| bank_open_o | output | 4 | Open flag per bank |
| power_down_o | output | 1 | Decoding suspended by clock enable |

## Verification
The assertions assume that reset is applied before any check counts. They also assume that the strobes, bank bits and address are stable across each rising edge. The bench meets both conditions by driving every input on the falling edge. The stimulus sweeps every strobe pattern against every bank and both values of address bit 10. It repeats the sweep with clock enable toggling, so that open, closed and illegal bank transitions all occur.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;

  // strobe levels -> command, chip select gates everything
  function automatic cmd_e strobe_to_cmd(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sdcmd_clk_gate.sv
module sdcmd_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  output logic run_o,
  output logic pdown_o
);
  logic cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  assign run_o   = cke_q;
  assign pdown_o = ~cke_q;

  AST_PDOWN_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i) |=> pdown_o); // R3
endmodule

// File: rtl/sdcmd_bank_track.sv
module sdcmd_bank_track #(
  parameter int BANKS = 4,
  parameter int ROW_W = 12,
  parameter int BA_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             rw_i,
  input  logic             ap_i,
  input  logic             pre_i,
  input  logic             pre_all_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [BANKS-1:0] open_o,
  output logic             sel_open_o,
  output logic [ROW_W-1:0] sel_row_o
);
  logic [BANKS-1:0] open_q;
  logic [ROW_W-1:0] row_q [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BA_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[g] <= 1'b0;
        row_q[g]  <= '0;
      end else if (act_i && hit && !open_q[g]) begin
        open_q[g] <= 1'b1;
        row_q[g]  <= row_i;
      end else if (pre_i && (pre_all_i || hit)) begin
        open_q[g] <= 1'b0;
      end else if (rw_i && ap_i && hit) begin
        open_q[g] <= 1'b0;
      end
    end
  end

  assign open_o     = open_q;
  assign sel_open_o = open_q[bank_i];
  assign sel_row_o  = open_q[bank_i] ? row_q[bank_i] : '0;

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && pre_all_i) |=> (open_q == '0)); // R7
  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !sel_open_o) |=> (open_q[$past(bank_i)] && row_q[$past(bank_i)] == $past(row_i))); // R4
  AST_ACT_ERR_KEEPS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && sel_open_o) |=> $stable(row_q[$past(bank_i)])); // R9
  AST_AP_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rw_i && ap_i) |=> !open_q[$past(bank_i)]); // R6
endmodule

// File: rtl/sdram_cmd_frontend.sv
module sdram_cmd_frontend
  import sdcmd_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cke_i,
  input  logic                       cs_ni,
  input  logic                       ras_ni,
  input  logic                       cas_ni,
  input  logic                       we_ni,
  input  logic [$clog2(BANKS)-1:0]   ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  output logic [2:0]                 cmd_o,
  output logic [$clog2(BANKS)-1:0]   bank_o,
  output logic [ROW_W-1:0]           row_o,
  output logic [COL_W-1:0]           col_o,
  output logic                       auto_pre_o,
  output logic                       all_banks_o,
  output logic                       proto_err_o,
  output logic [BANKS-1:0]           bank_open_o,
  output logic                       power_down_o
);
  localparam int BA_W = $clog2(BANKS);

  logic run, sel_open;
  logic [ROW_W-1:0] sel_row;
  cmd_e cmd_now;
  logic ev_act, ev_rw, ev_pre, a10, err_now;

  sdcmd_clk_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cke_i  (cke_i),
    .run_o  (run),
    .pdown_o(power_down_o)
  );

  assign cmd_now = run ? strobe_to_cmd(cs_ni, ras_ni, cas_ni, we_ni) : CMD_NOP;
  assign ev_act  = (cmd_now == CMD_ACT);
  assign ev_rw   = is_access(cmd_now);
  assign ev_pre  = (cmd_now == CMD_PRE);
  assign a10     = addr_i[AP_BIT];
  assign err_now = (ev_act && sel_open) || (ev_rw && !sel_open);

  sdcmd_bank_track #(.BANKS(BANKS), .ROW_W(ROW_W), .BA_W(BA_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (ev_act),
    .rw_i      (ev_rw),
    .ap_i      (a10),
    .pre_i     (ev_pre),
    .pre_all_i (a10),
    .bank_i    (ba_i),
    .row_i     (addr_i),
    .open_o    (bank_open_o),
    .sel_open_o(sel_open),
    .sel_row_o (sel_row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= CMD_NOP;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      auto_pre_o  <= 1'b0;
      all_banks_o <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      cmd_o       <= cmd_now;
      bank_o      <= (cmd_now == CMD_NOP) ? '0 : ba_i;
      row_o       <= ev_act ? addr_i : (ev_rw ? sel_row : '0);
      col_o       <= ev_rw ? addr_i[COL_W-1:0] : '0;
      auto_pre_o  <= ev_rw & a10;
      all_banks_o <= ev_pre & a10;
      proto_err_o <= err_now;
    end
  end

  AST_CS_HIGH_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o == CMD_NOP)); // R2
  AST_SUSPEND_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i) |-> ##2 (cmd_o == CMD_NOP)); // R3
  AST_RW_CLOSED_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_rw && !sel_open) |=> proto_err_o); // R9
  AST_PRE_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_pre && !a10) |=> !bank_open_o[$past(ba_i)]); // R8
endmodule

// File: tb/sdram_cmd_frontend_test.sv
module sdram_cmd_frontend_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [2:0] cmd;
  logic [1:0] bank;
  logic [11:0] row;
  logic [7:0] col;
  logic ap, allb, err, pdown;
  logic [3:0] bopen;

  int n_chk = 0, n_fail = 0;
  bit m_run = 1'b1;
  bit m_open [4];
  int m_row [4];

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_frontend uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .cmd_o(cmd),
    .bank_o(bank), .row_o(row), .col_o(col), .auto_pre_o(ap),
    .all_banks_o(allb), .proto_err_o(err), .bank_open_o(bopen),
    .power_down_o(pdown)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int code_of(input bit c, input bit r, input bit k, input bit w);
    if (c) return 0;
    if (!r && k && w) return 1;
    if (r && !k && w) return 2;
    if (r && !k && !w) return 3;
    if (!r && k && !w) return 4;
    if (!r && !k && w) return 5;
    if (!r && !k && !w) return 6;
    return 0;
  endfunction

  task automatic step(input bit ck, input bit c, input bit r, input bit k,
                      input bit w, input int b, input int a);
    int ec, erow, ecol, eap, eall, eerr, eopen;
    bit a10;
    cke = ck; cs_n = c; ras_n = r; cas_n = k; we_n = w;
    ba = 2'(b); addr = 12'(a);
    @(negedge clk);
    a10 = a[10];
    ec = m_run ? code_of(c, r, k, w) : 0;
    erow = 0; ecol = 0; eap = 0; eall = 0; eerr = 0;
    if (ec == 1) begin erow = a & 12'hFFF; eerr = m_open[b]; end
    if (ec == 2 || ec == 3) begin
      erow = m_open[b] ? m_row[b] : 0; ecol = a & 8'hFF; eap = a10; eerr = !m_open[b];
    end
    if (ec == 4) eall = a10;
    if (!m_run) chk("R3 suspended cmd", cmd, 0);
    else if (c) chk("R2 deselect cmd", cmd, 0);
    else chk("R1 decode", cmd, ec);
    chk(ec == 1 ? "R4 act fields" : (ec == 2 || ec == 3) ? "R5 access fields" :
        ec == 4 ? "R7 R8 pre fields" : "R11 unused fields",
        {bank, row, col, ap, allb}, {ec == 0 ? 2'd0 : 2'(b), 12'(erow), 8'(ecol), 1'(eap), 1'(eall)});
    chk("R9 protocol error", err, eerr);
    // model update
    if (ec == 1 && !m_open[b]) begin m_open[b] = 1; m_row[b] = a & 12'hFFF; end
    if (ec == 4) begin
      for (int i = 0; i < 4; i++) if (a10 || i == b) m_open[i] = 0;
    end
    if ((ec == 2 || ec == 3) && a10) m_open[b] = 0;
    eopen = 0;
    for (int i = 0; i < 4; i++) eopen |= int'(m_open[i]) << i;
    chk((ec == 2 || ec == 3) ? "R6 open flags" : ec == 4 ? "R7 R8 open flags" : "R4 open flags",
        bopen, eopen);
    chk("R3 power down", pdown, !ck);
    m_run = ck;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset cmd", cmd, 0);
    chk("R10 reset banks", bopen, 0);
    chk("R10 reset err", err, 0);
    chk("R10 reset pdown", pdown, 0);
    // full strobe sweep, clock enable always high
    for (int rep = 0; rep < 2; rep++)
      for (int s = 0; s < 16; s++)
        for (int b = 0; b < 4; b++)
          for (int x = 0; x < 2; x++) begin
            int a;
            a = ((s * 97 + b * 13 + rep * 211) & 12'hBFF) | (x << 10);
            step(1, s[3], s[2], s[1], s[0], b, a);
          end
    // directed clock-enable sequence
    step(1, 0, 0, 1, 0, 0, 12'h400);  // precharge all
    step(0, 0, 0, 1, 1, 0, 12'h111);  // activate still decoded
    step(0, 0, 0, 1, 1, 1, 12'h222);  // ignored
    step(1, 0, 0, 1, 1, 2, 12'h333);  // ignored, leaving power-down
    step(1, 0, 0, 1, 1, 3, 12'h444);  // decoded again
    step(1, 0, 1, 0, 1, 0, 12'h0AB);  // read open bank
    step(1, 0, 1, 0, 0, 1, 12'h0CD);  // write closed bank -> error
    // sweep with clock enable toggling
    for (int s = 0; s < 64; s++) begin
      int a;
      a = (s * 331) & 12'hFFF;
      step((s % 5) != 2, 1'b0, s[0], s[1] ^ s[3], s[2], s[4] + s[5] * 2, a);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule